// File: doc/BRIEF.md
# Multi-Digit Radix Adder with Resolved Carries

This block adds two vectors of N digits, each digit W bits wide, in a radix set at run time. The radix may be anything from 2 up to 2^W. Digit 0 is the least significant digit. It occupies bits [W-1:0] of each digit bus, and digit i sits at bits [i*W +: W].

Carries do not ripple from digit to digit. Each digit first forms the plain sum of its two operands. From that sum it derives a generate bit, set when the sum exceeds radix-1, and a propagate bit, set when the sum equals radix-1. These bits are packed into two N-bit words, P and G. One binary add-and-xor, ((P|G)+G+cin)^P, then gives the carry into every digit at once.

The external carry-in enters that add as its carry input. It is not OR-ed into G: that would mark digit 0 as generating, and its carry would go to digit 1 instead of digit 0. Each digit then folds in its carry and wraps modulo the radix. The results, a carry-out and a flag are registered together with a valid bit. The flag reports that a carry actually travelled through at least one digit in the propagate state.

Top module: `radix_carry_prop`

## Requirements
- R1: For an accepted input, every result digit i equals (A_i + B_i + k_i) mod radix, where k_i is the carry into digit i. Operand digits are assumed to be below the radix.
- R2: A digit whose plain sum A_i+B_i is greater than radix-1 sends a carry to the digit above it whatever that digit's own carry-in is. A digit whose plain sum equals radix-1 passes on its incoming carry. Any other digit absorbs its incoming carry.
- R3: A carry travels through any number of consecutive propagating digits in one evaluation, reaching the first digit above them that does not propagate.
- R4: `carry_in` is the carry into digit 0.
- R5: `carry_out` is the carry leaving digit N-1.
- R6: `prop_flag` is 1 exactly when at least one digit with A_i+B_i == radix-1 receives a carry-in. It is 0 when no carry passed through such a digit, even if digits generated carries.
- R7: Results appear one clock after `in_valid` is high, with `out_valid` high for that one cycle. `out_valid` is low in the cycle after `in_valid` is low.
- R8: While `in_valid` is low, `sum_digits`, `carry_out` and `prop_flag` keep their last values whatever the operands do.
- R9: After reset, `out_valid`, `sum_digits`, `carry_out` and `prop_flag` are all zero.
- R10: The radix works at both ends of its range. Radix 2^W gives plain binary addition of the packed words. Radix 2 gives one-bit digits stored in W-bit fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present this cycle |
| a_digits | input | N*W | Operand A, digit i at [i*W +: W] |
| b_digits | input | N*W | Operand B, same layout |
| radix | input | W+1 | Radix, 2 to 2^W |
| carry_in | input | 1 | Carry into digit 0 |
| out_valid | output | 1 | Registered results are new this cycle |
| sum_digits | output | N*W | Result digits, same layout |
| carry_out | output | 1 | Carry out of the top digit |
| prop_flag | output | 1 | A carry passed through a propagating digit |

## Verification
If a generate or propagate bit is computed wrongly, the error shows one cycle after acceptance. Every digit above the bad one, up to the next absorbing digit, comes out off by one, and `carry_out` may also be wrong. Long chains of radix-1 digits are therefore the sharpest test, because a single bad bit corrupts the whole chain in the same output word. A wrong wrap in the per-digit fold shows as a digit at or above the radix. A fault in the output register shows as results that change while `in_valid` is low, or as `out_valid` lasting more than one cycle.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
    localparam int unsigned DIGITS_DEF  = 8;
    localparam int unsigned DIGIT_W_DEF = 8;
endpackage

// File: rtl/rcp_digit_gp.sv
module rcp_digit_gp #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_dig,
    input  logic [W-1:0] b_dig,
    input  logic [W:0]   radix,
    output logic [W:0]   part_sum,
    output logic         gen,
    output logic         prop
);
    logic [W:0] top_val;

    always_comb begin
        part_sum = {1'b0, a_dig} + {1'b0, b_dig};
        top_val  = radix - 1'b1;
        gen      = part_sum > top_val;
        prop     = part_sum == top_val;
    end
endmodule

// File: rtl/rcp_carry_net.sv
module rcp_carry_net #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    input  logic         cin,
    output logic [N-1:0] carry_vec,
    output logic         cout,
    output logic         prop_seen
);
    logic [N:0] total;

    always_comb begin
        // carry-in enters as the add's own carry, so digit 0 receives it
        total     = {1'b0, prop | gen} + {1'b0, gen} + {{N{1'b0}}, cin};
        carry_vec = total[N-1:0] ^ prop;
        cout      = total[N];
        prop_seen = |(carry_vec & prop);
    end
endmodule

// File: rtl/rcp_digit_fix.sv
module rcp_digit_fix #(
    parameter int unsigned W = 8
) (
    input  logic [W:0]   part_sum,
    input  logic         carry_bit,
    input  logic [W:0]   radix,
    output logic [W-1:0] digit
);
    logic [W+1:0] full;
    logic [W+1:0] wrapped;

    always_comb begin
        full    = {1'b0, part_sum} + {{(W+1){1'b0}}, carry_bit};
        wrapped = (full >= {1'b0, radix}) ? full - {1'b0, radix} : full;
        digit   = wrapped[W-1:0];
    end
endmodule

// File: rtl/radix_carry_prop.sv
module radix_carry_prop #(
    parameter int unsigned N = rcp_pkg::DIGITS_DEF,
    parameter int unsigned W = rcp_pkg::DIGIT_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N*W-1:0] a_digits,
    input  logic [N*W-1:0] b_digits,
    input  logic [W:0]     radix,
    input  logic           carry_in,
    output logic           out_valid,
    output logic [N*W-1:0] sum_digits,
    output logic           carry_out,
    output logic           prop_flag
);
    localparam int unsigned BUS_W = N * W;

    typedef struct packed {
        logic             valid;
        logic [BUS_W-1:0] sum;
        logic             cout;
        logic             flag;
    } state_t;

    state_t state_d, state_q;

    logic [W:0]       psum [N];
    logic [N-1:0]     gen_vec;
    logic [N-1:0]     prop_vec;
    logic [N-1:0]     carry_vec;
    logic [BUS_W-1:0] fixed_sum;
    logic             net_cout;
    logic             net_seen;

    for (genvar i = 0; i < N; i++) begin : g_dig
        rcp_digit_gp #(.W(W)) gp_i (
            .a_dig    (a_digits[i*W +: W]),
            .b_dig    (b_digits[i*W +: W]),
            .radix    (radix),
            .part_sum (psum[i]),
            .gen      (gen_vec[i]),
            .prop     (prop_vec[i])
        );

        rcp_digit_fix #(.W(W)) fix_i (
            .part_sum  (psum[i]),
            .carry_bit (carry_vec[i]),
            .radix     (radix),
            .digit     (fixed_sum[i*W +: W])
        );
    end

    rcp_carry_net #(.N(N)) net_i (
        .gen       (gen_vec),
        .prop      (prop_vec),
        .cin       (carry_in),
        .carry_vec (carry_vec),
        .cout      (net_cout),
        .prop_seen (net_seen)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.sum  = fixed_sum;
            state_d.cout = net_cout;
            state_d.flag = net_seen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.valid;
    assign sum_digits = state_q.sum;
    assign carry_out  = state_q.cout;
    assign prop_flag  = state_q.flag;
endmodule

// File: rtl/rcp_checker.sv
module rcp_checker #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [N*W-1:0] a_digits,
    input logic [N*W-1:0] b_digits,
    input logic           carry_in,
    input logic           out_valid,
    input logic [N*W-1:0] sum_digits,
    input logic           carry_out,
    input logic           prop_flag
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid lost"); // R7

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid) else $error("valid stuck"); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_digits) && $stable(carry_out) && $stable(prop_flag)))
        else $error("outputs moved while idle"); // R8

    AST_ZERO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !carry_in && a_digits == '0 && b_digits == '0)
        |=> (sum_digits == '0 && !carry_out && !prop_flag))
        else $error("zero add not zero"); // R1
endmodule

bind radix_carry_prop rcp_checker #(.N(N), .W(W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .a_digits   (a_digits),
    .b_digits   (b_digits),
    .carry_in   (carry_in),
    .out_valid  (out_valid),
    .sum_digits (sum_digits),
    .carry_out  (carry_out),
    .prop_flag  (prop_flag)
);

// File: tb/radix_carry_prop_tb.sv
module radix_carry_prop_tb_top;
    localparam int N = 8;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N*W-1:0] a_digits = '0;
    logic [N*W-1:0] b_digits = '0;
    logic [W:0]     radix = 10;
    logic           carry_in = 1'b0;
    logic           out_valid;
    logic [N*W-1:0] sum_digits;
    logic           carry_out;
    logic           prop_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    radix_carry_prop #(.N(N), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_digits(a_digits), .b_digits(b_digits), .radix(radix),
        .carry_in(carry_in), .out_valid(out_valid), .sum_digits(sum_digits),
        .carry_out(carry_out), .prop_flag(prop_flag)
    );

    task automatic check(input string req, input string what,
                         input logic [N*W-1:0] got, input logic [N*W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // digit-serial reference: ripple one digit at a time
    task automatic ref_add(input logic [N*W-1:0] a, input logic [N*W-1:0] b,
                           input int rdx, input logic cin,
                           output logic [N*W-1:0] s, output logic co, output logic fl);
        int c = cin;
        s = '0;
        fl = 1'b0;
        for (int i = 0; i < N; i++) begin
            int ps = int'(a[i*W +: W]) + int'(b[i*W +: W]);
            int t = ps + c;
            if (ps == rdx - 1 && c == 1) fl = 1'b1;
            if (t >= rdx) begin
                t = t - rdx;
                c = 1;
            end else begin
                c = 0;
            end
            s[i*W +: W] = W'(t);
        end
        co = c[0];
    endtask

    function automatic logic [N*W-1:0] fill(input int d);
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(d);
        return v;
    endfunction

    task automatic run_case(input string req, input logic [N*W-1:0] a,
                            input logic [N*W-1:0] b, input int rdx, input logic cin);
        logic [N*W-1:0] es;
        logic eco, efl;
        ref_add(a, b, rdx, cin, es, eco, efl);
        @(negedge clk);
        a_digits = a; b_digits = b; radix = (W+1)'(rdx); carry_in = cin; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid", {{(N*W-1){1'b0}}, out_valid}, 1);
        check(req, "sum_digits", sum_digits, es);
        check(req, "carry_out", {{(N*W-1){1'b0}}, carry_out}, {{(N*W-1){1'b0}}, eco});
        check(req, "prop_flag", {{(N*W-1){1'b0}}, prop_flag}, {{(N*W-1){1'b0}}, efl});
    endtask

    task automatic test_reset();
        check("R9", "out_valid", {{(N*W-1){1'b0}}, out_valid}, 0);
        check("R9", "sum_digits", sum_digits, 0);
        check("R9", "carry_out", {{(N*W-1){1'b0}}, carry_out}, 0);
        check("R9", "prop_flag", {{(N*W-1){1'b0}}, prop_flag}, 0);
    endtask

    task automatic test_plain();
        logic [N*W-1:0] a, b;
        for (int i = 0; i < N; i++) begin
            a[i*W +: W] = W'(i % 5);
            b[i*W +: W] = W'((i + 1) % 4);
        end
        run_case("R1", a, b, 10, 1'b0);
    endtask

    task automatic test_full_chain();
        // all digits 9 in radix 10 with carry-in: zeros, carry-out, flag (R3 R4 R5 R6)
        run_case("R3", fill(9), fill(0), 10, 1'b1);
        check("R4", "digit0", {{(N*W-W){1'b0}}, sum_digits[W-1:0]}, 0);
        check("R5", "carry_out", {{(N*W-1){1'b0}}, carry_out}, 1);
    endtask

    task automatic test_gen_chain();
        logic [N*W-1:0] a = fill(1), b = fill(1);
        a[0 +: W] = 7; b[0 +: W] = 5;
        for (int i = 1; i < 4; i++) begin
            a[i*W +: W] = 9; b[i*W +: W] = 0;
        end
        run_case("R2", a, b, 10, 1'b0);
        check("R3", "digit4", {{(N*W-W){1'b0}}, sum_digits[4*W +: W]}, 3);
        check("R6", "prop_flag", {{(N*W-1){1'b0}}, prop_flag}, 1);
    endtask

    task automatic test_gen_absorb();
        logic [N*W-1:0] a = fill(2), b = fill(3);
        a[0 +: W] = 8; b[0 +: W] = 8;
        run_case("R6", a, b, 10, 1'b0);
        check("R6", "prop_flag no pass", {{(N*W-1){1'b0}}, prop_flag}, 0);
    endtask

    task automatic test_top_gen();
        logic [N*W-1:0] a = fill(1), b = fill(1);
        a[(N-1)*W +: W] = 15; b[(N-1)*W +: W] = 4;
        run_case("R5", a, b, 16, 1'b0);
        check("R5", "carry_out top", {{(N*W-1){1'b0}}, carry_out}, 1);
    endtask

    task automatic test_radix_ends();
        run_case("R10", fill(255), fill(0), 256, 1'b1);
        check("R10", "binary wrap", sum_digits, 0);
        run_case("R10", 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 256, 1'b0);
        check("R10", "binary sum", sum_digits, 64'h1234_5678_9ABC_DEF0 + 64'h0FED_CBA9_8765_4321);
        run_case("R10", 64'h0001_0100_0101_0001, 64'h0101_0001_0001_0100, 2, 1'b1);
    endtask

    task automatic test_hold();
        logic [N*W-1:0] prev;
        run_case("R8", fill(4), fill(4), 10, 1'b0);
        prev = sum_digits;
        a_digits = fill(9); b_digits = fill(9); carry_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8", "sum held", sum_digits, prev);
        check("R8", "flag held", {{(N*W-1){1'b0}}, prop_flag}, 0);
        check("R7", "out_valid idle", {{(N*W-1){1'b0}}, out_valid}, 0);
    endtask

    task automatic test_sweep();
        logic [31:0] lfsr = 32'hACE1_2345;
        int radixes[4] = '{3, 10, 100, 200};
        for (int k = 0; k < 24; k++) begin
            logic [N*W-1:0] a, b;
            int rdx = radixes[k % 4];
            for (int i = 0; i < N; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                a[i*W +: W] = W'(lfsr[15:0] % rdx);
                b[i*W +: W] = W'(lfsr[31:16] % rdx);
            end
            if (k % 3 == 0) b[W +: W] = W'(rdx - 1 - int'(a[W +: W]));
            run_case("R1", a, b, rdx, lfsr[5]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_plain();
        test_full_chain();
        test_gen_chain();
        test_gen_absorb();
        test_top_gen();
        test_radix_ends();
        test_hold();
        test_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule